// File: doc/BRIEF.md
# Integer Pixel Input Converter

This block sits on a stream of 8-bit or 16-bit integer image pixels. Each pixel first becomes a 17-bit signed value. A sign-override control decides whether the raw pattern is read as unsigned (zero-extended) or as signed (sign-extended). A programmable offset is then subtracted from that value. The difference is multiplied by a signed scale, arithmetically shifted right with round-to-nearest, and clipped to a signed 8-bit or 16-bit output range.

When conversion is switched off, each pixel is passed on as a native signed value and the override has no effect. Both the input and the output use a valid/ready handshake. The datapath has two register stages that advance together under one shared stall. A debug counter records every clipped result, and a flag reports when that count exceeds a software threshold. The counter is cleared by a layer-start pulse.

Top module: `pxcvt_top`

## Requirements
- R1: With conversion on and `cfg_force_uns`=1, an input pixel is zero-extended to 17 bits. An 8-bit pixel uses `in_data[7:0]`, so 0x87 becomes +135.
- R2: With conversion on and `cfg_force_uns`=0, an input pixel is sign-extended to 17 bits, so the 8-bit value 0x87 becomes -121.
- R3: `cfg_in16`=1 selects 16-bit input pixels using all of `in_data[15:0]`. Under each override setting, 0x8000 widens to +32768 or to -32768.
- R4: With conversion on, the result is ((x - `cfg_offset`) * `cfg_scale` + 2^(sh-1)) >>> sh, with sh = `cfg_shift`. Offset and scale are two's complement. When sh is 0, no rounding term is added.
- R5: `cfg_out16`=0 clips the converted result to [-128,127] and drives it sign-extended on `out_data[15:0]`. `cfg_out16`=1 clips it to [-32768,32767].
- R6: With `cfg_cvt_en`=0, `out_data` equals the input read as native signed data: an 8-bit pixel is sign-extended to 16 bits and a 16-bit pixel is unchanged. In this mode the override, offset, scale, shift and output width have no effect, and nothing is counted as clipped.
- R7: When `out_ready` is held high, a pixel accepted at rising edge t is on the output with `out_valid`=1 after edge t+1. Pixels leave in the order they arrive.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` is held and `in_ready` is 0. No pixel is lost or repeated.
- R9: `sat_count` increases by exactly one for each clipped result and does not change otherwise.
- R10: A `layer_start` pulse clears `sat_count` to 0 at the next edge. The clear wins over a clipped result that arrives at the same edge.
- R11: `sat_flag` is 1 exactly when `sat_count` > `cfg_sat_thresh`.
- R12: After reset, `out_valid`=0, `in_ready`=1, `sat_count`=0 and `sat_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layer_start | input | 1 | Pulse that clears the clip counter |
| cfg_cvt_en | input | 1 | 1 = convert, 0 = native pass-through |
| cfg_in16 | input | 1 | 1 = 16-bit input pixels, 0 = 8-bit |
| cfg_force_uns | input | 1 | 1 = read pixels as unsigned when converting |
| cfg_out16 | input | 1 | 1 = 16-bit output range, 0 = 8-bit |
| cfg_offset | input | 17 | Signed offset subtracted from the widened pixel |
| cfg_scale | input | 16 | Signed multiplier |
| cfg_shift | input | 5 | Right-shift amount |
| cfg_sat_thresh | input | CNT_W | Threshold for the clip flag |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter can take a pixel |
| in_data | input | 16 | Raw pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 16 | Converted pixel |
| sat_count | output | CNT_W | Number of clipped results since the last clear |
| sat_flag | output | 1 | Count above threshold |

## Verification
The checks assume that every configuration input stays constant while a pixel is inside the two stages, because a configuration change is not carried along with the data. The stimulus changes configuration only after the output side has drained. The checks also assume that `out_ready` may fall at any point. The stream scenario therefore drops it for several cycles with both stages full, and then toggles it irregularly. `layer_start` is pulsed both while the pipeline is idle and exactly on the edge at which a clipped result loads.

// File: rtl/pxcvt_pkg.sv
`timescale 1ns/1ps
package pxcvt_pkg;
  localparam int PX_W   = 16;
  localparam int HALF_W = 8;
  localparam int MID_W  = PX_W + 1;
  localparam int DIFF_W = MID_W + 1;
  localparam int SCL_W  = 16;
  localparam int PROD_W = DIFF_W + SCL_W;
  localparam int RND_W  = PROD_W + 1;
  localparam int SHF_W  = 5;

  typedef struct packed {
    logic [PX_W-1:0] val;
    logic            clip;
  } sat_res_t;

  // Widen a raw pixel to a signed intermediate; the override picks the extension.
  function automatic logic signed [MID_W-1:0] widen_px(input logic [PX_W-1:0] raw,
                                                      input logic wide,
                                                      input logic force_uns);
    logic signed [MID_W-1:0] r;
    if (wide)
      r = force_uns ? {1'b0, raw} : {raw[PX_W-1], raw};
    else
      r = force_uns ? {{(MID_W-HALF_W){1'b0}}, raw[HALF_W-1:0]}
                    : {{(MID_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
    return r;
  endfunction

  // Native signed view used when conversion is off.
  function automatic logic [PX_W-1:0] native_px(input logic [PX_W-1:0] raw, input logic wide);
    return wide ? raw : {{(PX_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
  endfunction

  // Arithmetic right shift with half-up rounding.
  function automatic logic signed [RND_W-1:0] round_shift(input logic signed [PROD_W-1:0] p,
                                                         input logic [SHF_W-1:0] sh);
    logic signed [RND_W-1:0] ext;
    logic signed [RND_W-1:0] half;
    logic signed [RND_W-1:0] sum;
    ext = RND_W'(p);
    if (sh == '0) return ext;
    half = {{(RND_W-1){1'b0}}, 1'b1} << (sh - SHF_W'(1));
    sum  = ext + half;
    return sum >>> sh;
  endfunction

  // Clip to a signed 8- or 16-bit range, sign-extended onto PX_W bits.
  function automatic sat_res_t clip_px(input logic signed [RND_W-1:0] v, input logic out16);
    logic signed [RND_W-1:0] hi;
    logic signed [RND_W-1:0] lo;
    sat_res_t r;
    hi = out16 ? RND_W'((1 << (PX_W-1)) - 1) : RND_W'((1 << (HALF_W-1)) - 1);
    lo = ~hi;
    if (v > hi) begin
      r.val  = PX_W'(hi);
      r.clip = 1'b1;
    end else if (v < lo) begin
      r.val  = PX_W'(lo);
      r.clip = 1'b1;
    end else begin
      r.val  = PX_W'(v);
      r.clip = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/pxcvt_front.sv
`timescale 1ns/1ps
module pxcvt_front import pxcvt_pkg::*; (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  logic [PX_W-1:0]          in_data,
  input  logic                     cfg_cvt_en,
  input  logic                     cfg_in16,
  input  logic                     cfg_force_uns,
  input  logic [MID_W-1:0]         cfg_offset,
  input  logic [SCL_W-1:0]         cfg_scale,
  output logic                     s1_valid,
  output logic signed [PROD_W-1:0] s1_prod,
  output logic [PX_W-1:0]          s1_pass,
  output logic                     s1_en
);
  logic signed [MID_W-1:0]  x_wide;
  logic signed [DIFF_W-1:0] x_diff;
  logic signed [PROD_W-1:0] x_prod;

  always_comb begin
    x_wide = widen_px(in_data, cfg_in16, cfg_force_uns);
    x_diff = DIFF_W'(x_wide) - DIFF_W'($signed(cfg_offset));
    x_prod = PROD_W'(x_diff) * PROD_W'($signed(cfg_scale));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_pass  <= '0;
      s1_en    <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= x_prod;
        s1_pass <= native_px(in_data, cfg_in16);
        s1_en   <= cfg_cvt_en;
      end
    end
  end
endmodule

// File: rtl/pxcvt_back.sv
`timescale 1ns/1ps
module pxcvt_back import pxcvt_pkg::*; (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     s1_valid,
  input  logic signed [PROD_W-1:0] s1_prod,
  input  logic [PX_W-1:0]          s1_pass,
  input  logic                     s1_en,
  input  logic [SHF_W-1:0]         cfg_shift,
  input  logic                     cfg_out16,
  output logic                     out_valid,
  output logic [PX_W-1:0]          out_data,
  output logic                     sat_load
);
  logic signed [RND_W-1:0] rnd;
  sat_res_t                sr;

  always_comb begin
    rnd      = round_shift(s1_prod, cfg_shift);
    sr       = clip_px(rnd, cfg_out16);
    sat_load = adv && s1_valid && s1_en && sr.clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_en ? sr.val : s1_pass;
    end
  end
endmodule

// File: rtl/pxcvt_satmon.sv
`timescale 1ns/1ps
module pxcvt_satmon #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_start,
  input  logic             sat_load,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (layer_start)                count <= '0;
    else if (sat_load && count != CNT_MAX) count <= count + CNT_W'(1);
  end

  assign flag = (count > thresh);
endmodule

// File: rtl/pxcvt_top.sv
`timescale 1ns/1ps
module pxcvt_top import pxcvt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_start,
  input  logic             cfg_cvt_en,
  input  logic             cfg_in16,
  input  logic             cfg_force_uns,
  input  logic             cfg_out16,
  input  logic [16:0]      cfg_offset,
  input  logic [15:0]      cfg_scale,
  input  logic [4:0]       cfg_shift,
  input  logic [CNT_W-1:0] cfg_sat_thresh,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_data,
  output logic [CNT_W-1:0] sat_count,
  output logic             sat_flag
);
  logic                     adv;
  logic                     s1_valid;
  logic signed [PROD_W-1:0] s1_prod;
  logic [PX_W-1:0]          s1_pass;
  logic                     s1_en;
  logic                     sat_load;

  // One stall for both stages: move only when the output slot frees up.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  pxcvt_front front_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(in_valid), .in_data(in_data),
    .cfg_cvt_en(cfg_cvt_en), .cfg_in16(cfg_in16), .cfg_force_uns(cfg_force_uns),
    .cfg_offset(cfg_offset), .cfg_scale(cfg_scale),
    .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_pass(s1_pass), .s1_en(s1_en)
  );

  pxcvt_back back_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_pass(s1_pass), .s1_en(s1_en),
    .cfg_shift(cfg_shift), .cfg_out16(cfg_out16),
    .out_valid(out_valid), .out_data(out_data), .sat_load(sat_load)
  );

  pxcvt_satmon #(.CNT_W(CNT_W)) satmon_i (
    .clk(clk), .rst_n(rst_n), .layer_start(layer_start), .sat_load(sat_load),
    .thresh(cfg_sat_thresh), .count(sat_count), .flag(sat_flag)
  );
endmodule

// File: rtl/pxcvt_chk.sv
`timescale 1ns/1ps
module pxcvt_chk import pxcvt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PX_W-1:0]  out_data,
  input logic             sat_load,
  input logic [CNT_W-1:0] sat_count,
  input logic             layer_start,
  input logic             cfg_cvt_en,
  input logic             cfg_out16
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_start |=> sat_count == '0);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !layer_start && !sat_load |=> $stable(sat_count));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !layer_start && sat_load && sat_count != '1 |=> sat_count == $past(sat_count) + CNT_W'(1));

  // R6
  bypass_nosat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cvt_en && !$past(cfg_cvt_en) |-> !sat_load);

  // R5
  range8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_cvt_en && !cfg_out16 |->
      (out_data[PX_W-1:HALF_W-1] == '0 || out_data[PX_W-1:HALF_W-1] == '1));
endmodule

bind pxcvt_top pxcvt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .sat_load(sat_load), .sat_count(sat_count),
  .layer_start(layer_start), .cfg_cvt_en(cfg_cvt_en), .cfg_out16(cfg_out16)
);

// File: tb/pxcvt_top_tb_top.sv
`timescale 1ns/1ps
module pxcvt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        layer_start = 1'b0;
  logic        cfg_cvt_en, cfg_in16, cfg_force_uns, cfg_out16;
  logic [16:0] cfg_offset;
  logic [15:0] cfg_scale;
  logic [4:0]  cfg_shift;
  logic [31:0] cfg_sat_thresh;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [31:0] sat_count;
  logic        sat_flag;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit done = 0;
  int b_ofs, b_scl, b_sh;

  always #4 clk = ~clk;

  pxcvt_top dut_i (
    .clk(clk), .rst_n(rst_n), .layer_start(layer_start),
    .cfg_cvt_en(cfg_cvt_en), .cfg_in16(cfg_in16), .cfg_force_uns(cfg_force_uns),
    .cfg_out16(cfg_out16), .cfg_offset(cfg_offset), .cfg_scale(cfg_scale),
    .cfg_shift(cfg_shift), .cfg_sat_thresh(cfg_sat_thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sat_count(sat_count), .sat_flag(sat_flag)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model written from the requirements with plain integer arithmetic.
  function automatic int ref_conv(input int raw, output bit clip);
    int x;
    int lim;
    longint p, d, num, q;
    clip = 0;
    if (!cfg_cvt_en) begin
      if (cfg_in16) return raw & 16'hFFFF;
      x = raw & 255;
      if (x >= 128) x -= 256;
      return x & 16'hFFFF;
    end
    if (cfg_in16) begin
      x = raw & 16'hFFFF;
      if (!cfg_force_uns && x >= 32768) x -= 65536;
    end else begin
      x = raw & 255;
      if (!cfg_force_uns && x >= 128) x -= 256;
    end
    p = longint'(x - b_ofs) * longint'(b_scl);
    if (b_sh == 0) q = p;
    else begin
      d   = longint'(1) << b_sh;
      num = p + d / 2;
      q   = num / d;
      if ((num % d) != 0 && num < 0) q -= 1;
    end
    lim = cfg_out16 ? 32767 : 127;
    if (q > lim) begin q = lim; clip = 1; end
    else if (q < -lim - 1) begin q = -lim - 1; clip = 1; end
    return int'(q) & 16'hFFFF;
  endfunction

  task automatic set_cfg(input bit en, input bit in16, input bit uns, input bit o16,
                         input int ofs, input int scl, input int sh);
    @(negedge clk);
    cfg_cvt_en = en; cfg_in16 = in16; cfg_force_uns = uns; cfg_out16 = o16;
    b_ofs = ofs; b_scl = scl; b_sh = sh;
    cfg_offset = 17'(ofs); cfg_scale = 16'(scl); cfg_shift = 5'(sh);
  endtask

  task automatic send_one(input int raw, input string req);
    bit clip;
    int exp;
    exp = ref_conv(raw, clip);
    if (clip) exp_cnt++;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_data = 16'(raw);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R7", "valid one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7", "valid two edges after accept", int'(out_valid), 1);
    chk(int'(out_data) == exp, req, "converted pixel", int'(out_data), exp);
    chk(int'(sat_count) == exp_cnt, "R9", "clip count", int'(sat_count), exp_cnt);
    chk(sat_flag == (exp_cnt > int'(cfg_sat_thresh)), "R11", "flag", int'(sat_flag),
        int'(exp_cnt > int'(cfg_sat_thresh)));
  endtask

  task automatic test_sign_override();
    set_cfg(1, 0, 0, 1, 0, 1, 0);
    send_one(16'h0087, "R2");
    send_one(16'h0005, "R2");
    set_cfg(1, 0, 1, 1, 0, 1, 0);
    send_one(16'h0087, "R1");
    send_one(16'hFF87, "R1");
  endtask

  task automatic test_wide_input();
    set_cfg(1, 1, 1, 1, 0, 1, 0);
    send_one(16'h8000, "R3");
    set_cfg(1, 1, 0, 1, 0, 1, 0);
    send_one(16'h8000, "R3");
  endtask

  task automatic test_round_shift();
    set_cfg(1, 0, 0, 1, 10, 3, 2);
    send_one(16'h0021, "R4");
    send_one(16'h0005, "R4");
    send_one(16'h000B, "R4");
    set_cfg(1, 1, 0, 1, -300, -5, 4);
    send_one(16'h0100, "R4");
  endtask

  task automatic test_saturate();
    set_cfg(1, 0, 1, 0, 0, 1, 0);
    send_one(16'h0087, "R5");
    set_cfg(1, 1, 0, 0, 0, 1, 0);
    send_one(16'h8000, "R5");
    send_one(16'h0040, "R5");
  endtask

  task automatic test_bypass();
    set_cfg(0, 0, 1, 0, 50, 7, 3);
    send_one(16'h0087, "R6");
    set_cfg(0, 1, 1, 0, 50, 7, 3);
    send_one(16'h8123, "R6");
  endtask

  task automatic test_layer_clear();
    @(negedge clk);
    layer_start = 1'b1;
    @(negedge clk);
    layer_start = 1'b0;
    exp_cnt = 0;
    chk(sat_count == 0, "R10", "clear while idle", int'(sat_count), 0);
    chk(sat_flag == 1'b0, "R11", "flag after clear", int'(sat_flag), 0);
    // Clear coincides with a clipped result entering the output stage.
    set_cfg(1, 0, 1, 0, 0, 1, 0);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_data = 16'h0087;
    @(negedge clk);
    in_valid = 1'b0; layer_start = 1'b1;
    @(negedge clk);
    layer_start = 1'b0;
    chk(out_valid && out_data == 16'h007F, "R5", "clipped pixel", int'(out_data), 16'h007F);
    chk(sat_count == 0, "R10", "clear wins over clip", int'(sat_count), 0);
  endtask

  task automatic test_stream();
    int pix[6] = '{10, 70, 156, 3, 64, 127};
    int exp[6];
    int idx_in = 0;
    int idx_out = 0;
    bit prev_acc = 0;
    bit prev_stall = 0;
    logic [15:0] prev_data = '0;
    bit clip;
    set_cfg(1, 0, 0, 0, 0, 2, 0);
    for (int i = 0; i < 6; i++) begin
      exp[i] = ref_conv(pix[i], clip);
      if (clip) exp_cnt++;
    end
    for (int cyc = 0; cyc < 80 && idx_out < 6; cyc++) begin
      @(negedge clk);
      if (prev_acc) idx_in++;
      in_valid  = (idx_in < 6);
      in_data   = (idx_in < 6) ? 16'(pix[idx_in]) : 16'h0;
      out_ready = (cyc >= 5) && (cyc % 3 != 0);
      #1;
      prev_acc = in_valid && in_ready;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8", "held under stall", int'(out_data), int'(prev_data));
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R8", "input blocked under stall", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        chk(int'(out_data) == exp[idx_out], "R7", "stream order", int'(out_data), exp[idx_out]);
        idx_out++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk(idx_out == 6, "R8", "all pixels delivered", idx_out, 6);
    @(negedge clk);
    chk(int'(sat_count) == exp_cnt, "R9", "stream clip count", int'(sat_count), exp_cnt);
    chk(out_valid == 1'b0, "R8", "no repeated pixel", int'(out_valid), 0);
  endtask

  initial begin
    cfg_sat_thresh = 32'd2;
    cfg_cvt_en = 1'b1; cfg_in16 = 1'b0; cfg_force_uns = 1'b0; cfg_out16 = 1'b1;
    cfg_offset = '0; cfg_scale = 16'd1; cfg_shift = '0;
    b_ofs = 0; b_scl = 1; b_sh = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R12", "ready after reset", int'(in_ready), 1);
    chk(sat_count == 0, "R12", "count after reset", int'(sat_count), 0);
    chk(sat_flag == 1'b0, "R12", "flag after reset", int'(sat_flag), 0);
    test_sign_override();
    test_wide_input();
    test_round_shift();
    test_saturate();
    test_bypass();
    test_layer_clear();
    test_stream();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule